// File: doc/BRIEF.md
# Single-Bus Accumulator Processor

This block is a small 8-bit processor that keeps its working result in one accumulator. Its parts are a program counter, an instruction register, the accumulator, an operand register that feeds the adder, and a 16-byte memory that holds both the program and its data. They all exchange values over one internal bus. A six-step one-hot ring counter sets the pace. On each step, the upper nibble of the current instruction selects which part drives the bus and which parts capture it.

Before the processor runs, the program and its data are written into memory through a load port while reset is held. Once reset is released, the processor fetches one byte per instruction and executes it. The result can be watched on the accumulator output, along with the zero flag from the last addition. The HALT instruction stops the processor, and a halted output reports that it has stopped.

Top module: `acc_cpu`

## Requirements
- R1: While `rst` is high at a clock edge, the accumulator, the zero flag and `halted` are cleared to 0, the program counter goes to 0 and the sequencer returns to its first fetch step.
- R2: Each instruction byte has two fields. The opcode is in bits 7:4 (LOAD=0x1, ADD=0x2, STORE=0x3, HALT=0xF). The memory address is in bits 3:0. LOAD copies the byte at that address into the accumulator, and the new value appears 3 clock edges after the instruction's first fetch edge.
- R3: ADD first moves the byte at the address into the operand register. On the following edge it writes accumulator + byte (mod 256) into the accumulator, 4 edges after the first fetch edge. The accumulator is unchanged one edge earlier.
- R4: STORE writes the accumulator into the memory byte at the address. A later LOAD of that address returns the stored value.
- R5: HALT sets `halted` 3 edges after its first fetch edge. From then until reset, `halted` stays 1 and the accumulator, the program counter and the sequencer hold their values.
- R6: An opcode other than 0x1, 0x2, 0x3 or 0xF changes nothing, and execution continues with the next byte.
- R7: Every instruction takes exactly six clock cycles: a fetch step, a program-counter increment step, and four execute or idle steps. Instructions are fetched from consecutive addresses starting at 0. At most one source drives the bus in any step.
- R8: While `prog_we` is high, each clock edge writes `prog_data` into the memory byte at `prog_addr`. The processor later reads those bytes as code and data.
- R9: `zero_flag` is updated only when ADD writes the accumulator. It is 1 exactly when that sum is 0 mod 256. LOAD, STORE and no-op instructions leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prog_we | input | 1 | Memory load strobe |
| prog_addr | input | 4 | Memory load address |
| prog_data | input | 8 | Memory load byte |
| halted | output | 1 | High once HALT has executed |
| acc_out | output | 8 | Accumulator value |
| zero_flag | output | 1 | Zero result of the last ADD |

## Verification
The assertions assume that `prog_we` is used only while `rst` is held. A write from the load port during execution would change memory in a way the sequencing properties do not model. The stimulus follows this rule: it writes all 16 bytes, drops `prog_we`, and only then releases reset. Each run executes a fixed program made of LOAD, ADD, STORE, a reload of the stored byte, one undefined opcode and HALT. Across the runs, the operands cover a grid of 256 pairs that includes carries out of bit 7 and sums that wrap to zero.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

    localparam int DATA_W    = 8;
    localparam int OP_W      = 4;
    localparam int ADDR_W    = DATA_W - OP_W;
    localparam int MEM_DEPTH = 1 << ADDR_W;
    localparam int STEPS     = 6;

    localparam int T_FETCH = 0;
    localparam int T_INC   = 1;
    localparam int T_EX1   = 2;
    localparam int T_EX2   = 3;

    localparam logic [OP_W-1:0] OP_LOAD  = 4'h1;
    localparam logic [OP_W-1:0] OP_ADD   = 4'h2;
    localparam logic [OP_W-1:0] OP_STORE = 4'h3;
    localparam logic [OP_W-1:0] OP_HALT  = 4'hF;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [STEPS-1:0]  ring_t;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_MEM  = 2'd1,
        SRC_ACC  = 2'd2,
        SRC_SUM  = 2'd3
    } bus_src_e;

    typedef enum logic {
        ADR_PC   = 1'b0,
        ADR_OPND = 1'b1
    } adr_sel_e;

    typedef struct packed {
        bus_src_e src;
        adr_sel_e adr;
        logic     ir_ld;
        logic     pc_inc;
        logic     acc_ld;
        logic     opb_ld;
        logic     mem_wr;
        logic     halt_set;
        logic     flag_ld;
    } ctrl_t;

    function automatic ctrl_t decode(ring_t ring, logic [OP_W-1:0] op);
        ctrl_t c;
        c     = '0;
        c.src = SRC_NONE;
        c.adr = ADR_PC;
        if (ring[T_FETCH]) begin
            c.src   = SRC_MEM;
            c.ir_ld = 1'b1;
        end
        if (ring[T_INC]) begin
            c.pc_inc = 1'b1;
        end
        if (ring[T_EX1]) begin
            unique case (op)
                OP_LOAD:  begin c.src = SRC_MEM; c.adr = ADR_OPND; c.acc_ld = 1'b1; end
                OP_ADD:   begin c.src = SRC_MEM; c.adr = ADR_OPND; c.opb_ld = 1'b1; end
                OP_STORE: begin c.src = SRC_ACC; c.adr = ADR_OPND; c.mem_wr = 1'b1; end
                OP_HALT:  c.halt_set = 1'b1;
                default:  ;
            endcase
        end
        if (ring[T_EX2] && op == OP_ADD) begin
            c.src     = SRC_SUM;
            c.acc_ld  = 1'b1;
            c.flag_ld = 1'b1;
        end
        return c;
    endfunction

endpackage

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
    import acc_cpu_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  halt_set,
    output ring_t ring,
    output logic  halted
);
    ring_t ring_q;
    logic  halted_q;
    logic  advance;

    assign advance = !halted_q && !halt_set;

    always_ff @(posedge clk) begin
        if (rst) begin
            ring_q   <= ring_t'(1);
            halted_q <= 1'b0;
        end else begin
            if (advance) begin
                ring_q <= {ring_q[STEPS-2:0], ring_q[STEPS-1]};
            end
            if (halt_set) begin
                halted_q <= 1'b1;
            end
        end
    end

    assign ring   = ring_q;
    assign halted = halted_q;

    assert_ring_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $countones(ring_q) == 1);

    assert_halt_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        halted_q |=> (halted_q && $stable(ring_q)));

endmodule

// File: rtl/acc_cpu_ram.sv
module acc_cpu_ram
    import acc_cpu_pkg::*;
(
    input  logic  clk,
    input  logic  we,
    input  addr_t waddr,
    input  word_t wdata,
    input  addr_t raddr,
    output word_t rdata
);
    word_t cells [MEM_DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/acc_cpu_alu.sv
module acc_cpu_alu
    import acc_cpu_pkg::*;
(
    input  word_t a,
    input  word_t b,
    output word_t sum,
    output logic  zero
);
    assign sum  = a + b;
    assign zero = (sum == '0);
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
    import acc_cpu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  prog_we,
    input  logic [ADDR_W-1:0]     prog_addr,
    input  logic [DATA_W-1:0]     prog_data,
    output logic                  halted,
    output logic [DATA_W-1:0]     acc_out,
    output logic                  zero_flag
);
    addr_t pc_q;
    word_t ir_q, acc_q, opb_q;
    logic  zero_q;
    ring_t ring;
    ctrl_t ctrl;
    word_t bus, mem_rd, alu_sum;
    logic  alu_zero;
    addr_t mem_addr;
    logic  ram_we;
    addr_t ram_waddr;
    word_t ram_wdata;

    assign ctrl = decode(ring, ir_q[DATA_W-1 -: OP_W]);

    acc_cpu_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .halt_set (ctrl.halt_set),
        .ring     (ring),
        .halted   (halted)
    );

    assign mem_addr = (ctrl.adr == ADR_OPND) ? ir_q[ADDR_W-1:0] : pc_q;

    // the load port wins over a STORE; the processor is held in reset while loading
    assign ram_we    = prog_we || (ctrl.mem_wr && !rst);
    assign ram_waddr = prog_we ? prog_addr : mem_addr;
    assign ram_wdata = prog_we ? prog_data : bus;

    acc_cpu_ram u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (mem_addr),
        .rdata (mem_rd)
    );

    acc_cpu_alu u_alu (
        .a    (acc_q),
        .b    (opb_q),
        .sum  (alu_sum),
        .zero (alu_zero)
    );

    always_comb begin
        unique case (ctrl.src)
            SRC_MEM: bus = mem_rd;
            SRC_ACC: bus = acc_q;
            SRC_SUM: bus = alu_sum;
            default: bus = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            ir_q   <= '0;
            acc_q  <= '0;
            opb_q  <= '0;
            zero_q <= 1'b0;
        end else begin
            if (ctrl.ir_ld)  ir_q  <= bus;
            if (ctrl.pc_inc) pc_q  <= pc_q + 1'b1;
            if (ctrl.acc_ld) acc_q <= bus;
            if (ctrl.opb_ld) opb_q <= bus;
            if (ctrl.flag_ld) zero_q <= alu_zero;
        end
    end

    assign acc_out   = acc_q;
    assign zero_flag = zero_q;

    assert_fetch_from_mem_R7: assert property (@(posedge clk) disable iff (rst)
        ctrl.ir_ld |-> (ctrl.src == SRC_MEM && ctrl.adr == ADR_PC));

    assert_acc_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !ctrl.acc_ld |=> $stable(acc_q));

    assert_add_result_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl.acc_ld && ctrl.src == SRC_SUM) |=> (acc_q == $past(acc_q) + $past(opb_q)));

    assert_zero_matches_R9: assert property (@(posedge clk) disable iff (rst)
        ctrl.flag_ld |=> (zero_q == (acc_q == '0)));

    assert_pc_frozen_R5: assert property (@(posedge clk) disable iff (rst)
        halted |=> $stable(pc_q));

    assert_store_source_R4: assert property (@(posedge clk) disable iff (rst)
        ctrl.mem_wr |-> (ctrl.src == SRC_ACC && !ctrl.acc_ld));

endmodule

// File: tb/acc_cpu_test.sv
module acc_cpu_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       prog_we = 1'b0;
    logic [3:0] prog_addr = '0;
    logic [7:0] prog_data = '0;
    logic       halted;
    logic [7:0] acc_out;
    logic       zero_flag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    acc_cpu uut (
        .clk       (clk),
        .rst       (rst),
        .prog_we   (prog_we),
        .prog_addr (prog_addr),
        .prog_data (prog_data),
        .halted    (halted),
        .acc_out   (acc_out),
        .zero_flag (zero_flag)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_to(inout int now, input int target);
        while (now < target) begin
            @(negedge clk);
            now++;
        end
    endtask

    task automatic run_one(input logic [7:0] a, input logic [7:0] b, input logic [3:0] nop);
        logic [7:0] image [16];
        logic [7:0] sum;
        logic       zexp;
        int         k;
        for (int i = 0; i < 16; i++) image[i] = 8'h00;
        image[0]  = 8'h1E;            // LOAD 14
        image[1]  = 8'h2F;            // ADD 15
        image[2]  = 8'h3D;            // STORE 13
        image[3]  = 8'h1C;            // LOAD 12
        image[4]  = 8'h1D;            // LOAD 13
        image[5]  = {nop, 4'h3};      // undefined opcode
        image[6]  = 8'hF0;            // HALT
        image[12] = 8'h5A;
        image[13] = 8'h00;
        image[14] = a;
        image[15] = b;
        sum  = a + b;
        zexp = (sum == 8'h00);

        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 16; i++) begin
            prog_we   = 1'b1;
            prog_addr = 4'(i);
            prog_data = image[i];
            @(negedge clk);
        end
        prog_we = 1'b0;
        // R1: state after reset
        check(acc_out == 8'h00 && halted == 1'b0 && zero_flag == 1'b0, "R1 reset state",
              {acc_out, halted, zero_flag}, 0);
        rst = 1'b0;
        k = 0;

        wait_to(k, 3);
        check(acc_out == a, "R2 LOAD result at edge 3", acc_out, a);
        wait_to(k, 9);
        check(acc_out == a, "R3 ADD not yet written", acc_out, a);
        wait_to(k, 10);
        check(acc_out == sum, "R3 ADD sum", acc_out, sum);
        check(zero_flag == zexp, "R9 zero flag after ADD", zero_flag, zexp);
        wait_to(k, 21);
        check(acc_out == 8'h5A, "R8 preloaded byte read", acc_out, 8'h5A);
        check(zero_flag == zexp, "R9 flag kept by LOAD", zero_flag, zexp);
        wait_to(k, 27);
        check(acc_out == sum, "R4 stored byte reloaded", acc_out, sum);
        wait_to(k, 33);
        check(acc_out == sum && halted == 1'b0, "R6 undefined opcode no effect",
              acc_out, sum);
        wait_to(k, 38);
        check(halted == 1'b0, "R7 halt not early", halted, 0);
        wait_to(k, 39);
        check(halted == 1'b1, "R5 halt at edge 39", halted, 1);
        wait_to(k, 60);
        check(halted == 1'b1 && acc_out == sum && zero_flag == zexp,
              "R5 frozen after halt", acc_out, sum);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        for (int ai = 0; ai < 16; ai++) begin
            for (int bi = 0; bi < 16; bi++) begin
                logic [7:0] a;
                logic [7:0] b;
                a = {4'(ai), 4'(bi)};
                b = (ai == bi) ? 8'(0 - a) : {4'(bi), 4'(ai)};
                run_one(a, b, 4'(4 + ((ai * 16 + bi) % 11)));
            end
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule